// File: doc/BRIEF.md
# Dual-Channel Power-Up Sequencer with Reset Generation

This block sequences the start of two regulator channels and produces one active-low reset per channel, plus a start pulse level for a downstream watchdog. Every analog event is already reduced to a digital flag: a global enable, a "feedback good" flag per channel and a "soft-start discharged" flag per channel. Each flag passes through a two-stage synchronizer before any logic uses it. The run enables, resets and watchdog start are all registered.

A 2-bit mode code chooses one of three behaviours. In the coupled mode, channel 2 waits for channel 1. Both resets are then released together, once both channels report good and the channel 1 delay has run out. In the tracked mode, channel 2 still waits for channel 1, but each reset follows its own channel. In the simultaneous mode, both channels start at once and each reset follows its own channel. The power-on delays are cycle counters whose lengths are inputs. When the enable is low, the whole block is held in shutdown.

Top module: `pwr_seq_rst_ctrl`

## Requirements
- R1: After reset, and on the third rising edge after `en_i` falls, `run1_o`, `run2_o`, `wd_start_o` are 0 and `rst1_no`, `rst2_no` are 0 (asserted).
- R2: Every flag input (`en_i`, `fbok1_i`, `fbok2_i`, `dis1_i`, `dis2_i`) is synchronized by two flops, so no output reacts to it before the third rising edge after it changes.
- R3: While enabled, a run enable rises on the third edge after its discharged flag rises and never before that flag is seen. It then stays high even if the flag drops, until shutdown.
- R4: In modes 2'b00, 2'b01 and 2'b11, `run2_o` also requires `fbok1_i` (it rises 3 edges after `fbok1_i`). In mode 2'b10 it does not.
- R5: In modes 2'b01 and 2'b10, a reset is released exactly N+3 edges after its feedback flag rises, where N is `por1_len_i` for channel 1 and `por2_len_i` for channel 2.
- R6: If a feedback flag drops, the reset(s) that depend on it go low on the third edge. A later rise restarts the delay from zero, so release again takes N+3 edges.
- R7: In mode 2'b00, both resets are released on the same edge: 1 edge after both flags are good and the channel 1 delay has expired.
- R8: In mode 2'b00, `por2_len_i` has no effect on either reset.
- R9: `wd_start_o` rises one edge after both resets are high in modes 2'b00, 2'b01 and 2'b11, and one edge after `rst1_no` is high in mode 2'b10.
- R10: Code 2'b11 behaves exactly as mode 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Global enable, asynchronous |
| fbok1_i | input | 1 | Channel 1 feedback good, asynchronous |
| fbok2_i | input | 1 | Channel 2 feedback good, asynchronous |
| dis1_i | input | 1 | Channel 1 soft-start discharged, asynchronous |
| dis2_i | input | 1 | Channel 2 soft-start discharged, asynchronous |
| mode_i | input | 2 | 00 coupled, 01 tracked, 10 simultaneous, 11 as 00 |
| por1_len_i | input | CNT_W | Channel 1 power-on delay in cycles |
| por2_len_i | input | CNT_W | Channel 2 power-on delay in cycles |
| run1_o | output | 1 | Channel 1 run enable |
| run2_o | output | 1 | Channel 2 run enable |
| rst1_no | output | 1 | Channel 1 reset, active low |
| rst2_no | output | 1 | Channel 2 reset, active low |
| wd_start_o | output | 1 | Watchdog may start |

## Verification
All four mode codes are swept against a grid of channel 1 and channel 2 delay lengths, including zero and the counter maximum. Channel 2's feedback is raised a fixed number of edges after channel 1's. The expected release edges therefore separate three cases: independent resets, resets coupled at the later of the two conditions, and a channel 2 delay that must be ignored. The bench also drops the channel 1 feedback and raises it again, which shows whether the reset reasserts on its own or together with the other and whether the timer truly restarts. It brings up the discharged flags before and after the enable to expose run-enable gating, and it removes the enable to check shutdown latency.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [1:0] {
    MODE_COUPLED = 2'b00,
    MODE_TRACK   = 2'b01,
    MODE_SIMUL   = 2'b10,
    MODE_RSVD    = 2'b11
  } seq_mode_e;

  // reserved code folds onto the coupled behaviour
  function automatic seq_mode_e decode_mode(input logic [1:0] code);
    seq_mode_e m;
    m = seq_mode_e'(code);
    if (m == MODE_RSVD) m = MODE_COUPLED;
    return m;
  endfunction
endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/por_timer.sv
module por_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!arm_i)         cnt_q <= '0;
    else if (cnt_q < len_i)  cnt_q <= cnt_q + 1'b1;
  end

  // >= keeps done stable if the length is lowered at run time
  assign done_o = arm_i && (cnt_q >= len_i);
endmodule

// File: rtl/run_gate.sv
module run_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic dis_i,
  input  logic order_ok_i,
  output logic run_o
);
  logic run_q;

  // latches on once discharge is seen and ordering allows; cleared only by shutdown
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= en_i && (run_q || (dis_i && order_ok_i));
  end

  assign run_o = run_q;
endmodule

// File: rtl/pwr_seq_rst_ctrl.sv
module pwr_seq_rst_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             fbok1_i,
  input  logic             fbok2_i,
  input  logic             dis1_i,
  input  logic             dis2_i,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] por1_len_i,
  input  logic [CNT_W-1:0] por2_len_i,
  output logic             run1_o,
  output logic             run2_o,
  output logic             rst1_no,
  output logic             rst2_no,
  output logic             wd_start_o
);
  localparam int NCH  = 2;
  localparam int NFLG = 1 + 2 * NCH;

  seq_mode_e        mode;
  logic             en_s;
  logic [NCH-1:0]   fb_s, dis_s, order_ok, run_q, done, rst_cond;
  logic [NCH-1:0]   rst_q;
  logic             wd_q;
  logic [CNT_W-1:0] len_arr [NCH];

  flag_sync #(.W(NFLG)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({en_i, fbok2_i, fbok1_i, dis2_i, dis1_i}),
    .q_o   ({en_s, fb_s, dis_s})
  );

  assign mode       = decode_mode(mode_i);
  assign len_arr[0] = por1_len_i;
  assign len_arr[1] = por2_len_i;

  // channel 2 waits for channel 1 feedback except in simultaneous mode
  assign order_ok[0] = 1'b1;
  assign order_ok[1] = (mode == MODE_SIMUL) || fb_s[0];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    run_gate u_run (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (en_s),
      .dis_i     (dis_s[ch]),
      .order_ok_i(order_ok[ch]),
      .run_o     (run_q[ch])
    );

    por_timer #(.CNT_W(CNT_W)) u_por (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .arm_i (en_s && fb_s[ch]),
      .len_i (len_arr[ch]),
      .done_o(done[ch])
    );
  end

  always_comb begin
    if (mode == MODE_COUPLED) begin
      rst_cond[0] = done[0] && fb_s[1];
      rst_cond[1] = done[0] && fb_s[1];
    end else begin
      rst_cond = done;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q <= '0;
      wd_q  <= 1'b0;
    end else begin
      rst_q <= {NCH{en_s}} & rst_cond;
      wd_q  <= en_s && ((mode == MODE_SIMUL) ? rst_q[0] : &rst_q);
    end
  end

  assign run1_o     = run_q[0];
  assign run2_o     = run_q[1];
  assign rst1_no    = rst_q[0];
  assign rst2_no    = rst_q[1];
  assign wd_start_o = wd_q;
endmodule

// File: rtl/pwr_seq_rst_ctrl_chk.sv
module pwr_seq_rst_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_s,
  input logic [1:0] fb_s,
  input logic [1:0] dis_s,
  input logic [1:0] mode_i,
  input logic       run1_o,
  input logic       run2_o,
  input logic       rst1_no,
  input logic       rst2_no,
  input logic       wd_start_o
);
  // R1
  shutdown_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_s |=> (!run1_o && !run2_o && !rst1_no && !rst2_no && !wd_start_o));

  // R3
  run1_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run1_o) |-> $past(dis_s[0]));

  // R4
  run2_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(run2_o) && (mode_i != 2'b10)) |-> ($past(fb_s[0]) && $past(dis_s[1])));

  // R6
  fb1_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fb_s[0] |=> !rst1_no);

  // R6
  fb2_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fb_s[1] |=> !rst2_no);

  // R7
  coupled_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i[1] == mode_i[0]) && $stable(mode_i)) |-> (rst1_no == rst2_no));

  // R9
  wd_after_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_start_o |-> $past(rst1_no));
endmodule

bind pwr_seq_rst_ctrl pwr_seq_rst_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_s      (en_s),
  .fb_s      (fb_s),
  .dis_s     (dis_s),
  .mode_i    (mode_i),
  .run1_o    (run1_o),
  .run2_o    (run2_o),
  .rst1_no   (rst1_no),
  .rst2_no   (rst2_no),
  .wd_start_o(wd_start_o)
);

// File: tb/pwr_seq_rst_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_seq_rst_ctrl_bench;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          en_i = 1'b0, fbok1_i = 1'b0, fbok2_i = 1'b0, dis1_i = 1'b0, dis2_i = 1'b0;
  logic [1:0]    mode_i = 2'b00;
  logic [CW-1:0] por1_len_i = '0, por2_len_i = '0;
  logic          run1_o, run2_o, rst1_no, rst2_no, wd_start_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pwr_seq_rst_ctrl #(.CNT_W(CW)) u_pwr_seq_rst_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .fbok1_i(fbok1_i), .fbok2_i(fbok2_i),
    .dis1_i(dis1_i), .dis2_i(dis2_i), .mode_i(mode_i),
    .por1_len_i(por1_len_i), .por2_len_i(por2_len_i),
    .run1_o(run1_o), .run2_o(run2_o), .rst1_no(rst1_no), .rst2_no(rst2_no),
    .wd_start_o(wd_start_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s mode=%0d l1=%0d l2=%0d act=%0d exp=%0d",
               req, mode_i, por1_len_i, por2_len_i, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic run_case(input int m, input int l1, input int l2);
    bit coupled, simul;
    int e_r1, e_r2, e_run2, e_wd, x_r1, x_r2;
    string rq;
    coupled = (m == 0) || (m == 3);
    simul   = (m == 2);
    rq      = (m == 3) ? "R10" : "R7";

    en_i = 0; fbok1_i = 0; fbok2_i = 0; dis1_i = 0; dis2_i = 0;
    mode_i = m[1:0]; por1_len_i = l1[CW-1:0]; por2_len_i = l2[CW-1:0];
    tick(4);
    chk("R1 idle", {run1_o, run2_o, rst1_no, rst2_no, wd_start_o}, 0);

    // enable without discharge: no run
    en_i = 1;
    tick(5);
    chk("R3 no discharge", run1_o, 0);
    dis1_i = 1; dis2_i = 1;
    tick(2);
    chk("R2 run1 latency", run1_o, 0);
    tick(1);
    chk("R3 run1 up", run1_o, 1);
    chk("R4 run2 before fb1", run2_o, simul ? 1 : 0);
    dis1_i = 0;
    tick(3);
    chk("R3 run1 holds", run1_o, 1);

    // feedback rise: fb1 now, fb2 after 6 edges
    e_r1 = -1; e_r2 = -1; e_wd = -1;
    e_run2 = run2_o ? 0 : -1;
    fbok1_i = 1;
    for (int k = 1; k <= 40; k++) begin
      tick(1);
      if (rst1_no && e_r1 < 0) e_r1 = k;
      if (rst2_no && e_r2 < 0) e_r2 = k;
      if (run2_o && e_run2 < 0) e_run2 = k;
      if (wd_start_o && e_wd < 0) e_wd = k;
      if (k == 6) fbok2_i = 1;
    end
    x_r1 = coupled ? imax(l1 + 3, 9) : l1 + 3;
    x_r2 = coupled ? imax(l1 + 3, 9) : l2 + 9;
    chk(coupled ? rq : "R5 rst1 release", e_r1, x_r1);
    chk(coupled ? "R8 rst2 release" : "R5 rst2 release", e_r2, x_r2);
    chk("R4 run2 start", e_run2, simul ? 0 : 3);
    chk("R9 wd start", e_wd, simul ? x_r1 + 1 : imax(x_r1, x_r2) + 1);

    // drop fb1
    e_r1 = -1; e_wd = -1;
    fbok1_i = 0;
    for (int k = 1; k <= 10; k++) begin
      tick(1);
      if (!rst1_no && e_r1 < 0) e_r1 = k;
      if (!wd_start_o && e_wd < 0) e_wd = k;
    end
    chk("R6 rst1 reassert", e_r1, 3);
    chk(coupled ? rq : "R6 rst2 independent", rst2_no, coupled ? 0 : 1);
    chk("R9 wd drop", e_wd, 4);

    // raise again: timer restarts from zero
    e_r1 = -1;
    fbok1_i = 1;
    for (int k = 1; k <= 24; k++) begin
      tick(1);
      if (rst1_no && e_r1 < 0) e_r1 = k;
    end
    chk("R6 restart", e_r1, l1 + 3);
    chk("R7 rst2 after restart", rst2_no, 1);

    // shutdown
    en_i = 0;
    tick(2);
    chk("R2 shutdown latency", run1_o, 1);
    tick(1);
    chk("R1 shutdown", {run1_o, run2_o, rst1_no, rst2_no, wd_start_o}, 0);
  endtask

  initial begin
    int l1s[4] = '{0, 1, 6, 15};
    int l2s[3] = '{0, 2, 15};
    tick(3);
    chk("R1 reset state", {run1_o, run2_o, rst1_no, rst2_no, wd_start_o}, 0);
    rst_ni = 1;
    tick(2);
    for (int m = 0; m < 4; m++)
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 3; b++)
          run_case(m, l1s[a], l2s[b]);
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule